// File: doc/BRIEF.md
# Abort Fault Status Capture Unit

This block turns abort events raised by a small processor pipeline into the architectural fault state that the abort handler reads. Each cycle it samples one-cycle pulses from three instruction-side sources (MMU exception on fetch, external bus error on fetch, instruction cache parity error). It also samples a lock-operation abort, a precise data MMU abort that carries a 4-bit subtype, and an imprecise data abort. It picks one event and records a 5-bit extended fault status code. It also records the abort-mode link value, a precise flag and a recoverable flag.

When a data MMU abort is the event taken, the fault address and domain registers are loaded from the data access. For every other class they keep their old contents, and a validity flag says whether they belong to the latest abort. A one-cycle strobe marks each capture. All registered state holds until the next abort or a synchronous active-low reset, which clears it to zero.

Top module: `abort_capture`

## Requirements
- R1: When several instruction-side sources pulse in the same cycle, only the highest one is recorded. The order from highest to lowest is fetch MMU exception, then external fetch error, then instruction cache parity error.
- R2: The status output `fs_code_o` is `{FS[10], FS[3:0]}` with FS[10] in bit 4. The instruction-side codes are 5'b10000 (fetch MMU), 5'b10110 (external fetch error) and 5'b11000 (cache parity).
- R3: An instruction-side abort sets the link to the aborted instruction address plus 4 and sets precise=1 and recoverable=1. It clears `addr_valid_o` and leaves `far_o` and `domain_o` unchanged.
- R4: A lock abort records code 5'b10100 and sets the link to the aborted instruction address plus 8, with precise=1 and recoverable=1. It clears `addr_valid_o` and leaves `far_o` and `domain_o` unchanged.
- R5: A data MMU abort records `{1'b0, dmmu_code_i}` and sets the link to the aborted instruction address plus 8, with precise=1 and recoverable=1. It loads `far_o` with the data address and `domain_o` with the access domain, and sets `addr_valid_o`.
- R6: An imprecise data abort records `{1'b0, dmmu_code_i}` and sets the link to `next_pc_i` plus 4, with precise=0 and recoverable=0. It clears `addr_valid_o` and leaves `far_o` and `domain_o` unchanged.
- R7: Among data-side events, lock wins over data MMU, and data MMU wins over imprecise. Any data-side event wins over all instruction-side events in the same cycle.
- R8: `cap_valid_o` is high in exactly the cycle after a cycle in which any abort input is high, and low otherwise.
- R9: In a cycle with no abort input, every registered output keeps its value.
- R10: After synchronous reset (`rst_n` low at a clock edge), every output is zero.
- R11: Link sums are taken modulo 2^AW, so an address near the top of the space wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pf_immu_i | input | 1 | Fetch MMU exception pulse (translation/domain/permission) |
| pf_ext_i | input | 1 | External bus error on fetch pulse |
| pf_parity_i | input | 1 | Instruction cache parity error pulse |
| lock_abort_i | input | 1 | Lock operation abort pulse |
| dmmu_abort_i | input | 1 | Precise data MMU abort pulse |
| imprecise_abort_i | input | 1 | Imprecise data abort pulse |
| dmmu_code_i | input | 4 | Data abort subtype, written to FS[3:0] |
| domain_i | input | DW | Domain of the faulting data access |
| abort_pc_i | input | AW | Address of the aborted instruction |
| next_pc_i | input | AW | Address of the next instruction to execute |
| data_addr_i | input | AW | Effective data address of the access |
| cap_valid_o | output | 1 | One-cycle capture strobe |
| fs_code_o | output | 5 | Extended fault status {FS[10],FS[3:0]} |
| far_o | output | AW | Fault address register |
| domain_o | output | DW | Captured domain |
| addr_valid_o | output | 1 | Address/domain belong to the latest abort |
| link_o | output | AW | Abort-mode link value |
| precise_o | output | 1 | Latest abort is precise |
| recoverable_o | output | 1 | Latest abort is recoverable |

## Verification
The assertions check on every cycle that the strobe follows each abort input by exactly one cycle and that the outputs stay stable across idle cycles. They also check that instruction-side captures leave the address register alone, that data MMU captures load it, and that imprecise captures are flagged non-recoverable. How the arbitration resolves each of the 64 combinations of simultaneous inputs, which exact code comes out for each, and the wrap of the link sum only show up in the bench's exhaustive sweep against its arithmetic model.

// File: rtl/abort_cap_pkg.sv
// Package: shared codes and types of the abort capture unit.
// Assumes a 5-bit status view {FS[10],FS[3:0]} with FS[10] in bit 4.
package abort_cap_pkg;

    localparam logic [4:0] FS_FETCH_MMU   = 5'b10000;
    localparam logic [4:0] FS_FETCH_EXT   = 5'b10110;
    localparam logic [4:0] FS_ICACHE_PAR  = 5'b11000;
    localparam logic [4:0] FS_LOCK        = 5'b10100;

    // Abort class that wins arbitration in a cycle.
    typedef enum logic [2:0] {
        CLS_NONE      = 3'd0,
        CLS_FETCH     = 3'd1,
        CLS_LOCK      = 3'd2,
        CLS_DMMU      = 3'd3,
        CLS_IMPRECISE = 3'd4
    } abort_cls_e;

    // Bundle of values to be registered on a capture.
    typedef struct packed {
        logic [4:0] code;
        logic       precise;
        logic       recoverable;
        logic       addr_update;
    } capture_attr_t;

endpackage

// File: rtl/abort_pf_prio.sv
// Module: fixed-priority one-hot grant over NSRC request lines.
// Index 0 is the highest priority. Pure combinational logic.
module abort_pf_prio #(
    parameter int NSRC = 3
) (
    input  logic [NSRC-1:0] req_i,
    output logic [NSRC-1:0] grant_o,
    output logic            any_o
);

    logic [NSRC-1:0] blocked;

    assign blocked[0] = 1'b0;

    // Build the chain of "a higher request is active" flags.
    genvar gi;
    generate
        for (gi = 1; gi < NSRC; gi++) begin : g_chain
            assign blocked[gi] = blocked[gi-1] | req_i[gi-1];
        end
    endgenerate

    // Grant only the first active request.
    assign grant_o = req_i & ~blocked;
    assign any_o   = |req_i;

endmodule

// File: rtl/abort_class_sel.sv
// Module: picks the abort class of the cycle and its status code.
// Data-side events rank above instruction-side ones; lock > data MMU > imprecise.
// Assumes fetch grant is one-hot in the order {parity, external, MMU}.
module abort_class_sel
    import abort_cap_pkg::*;
#(
    parameter int NPF = 3
) (
    input  logic [NPF-1:0] pf_grant_i,
    input  logic           pf_any_i,
    input  logic           lock_i,
    input  logic           dmmu_i,
    input  logic           imprecise_i,
    input  logic [3:0]     dmmu_code_i,
    output abort_cls_e     cls_o,
    output logic [4:0]     code_o
);

    logic [4:0] fetch_code;

    // Map the one-hot fetch grant onto its fixed status code.
    always_comb begin
        fetch_code = 5'b00000;
        for (int i = 0; i < NPF; i++) begin
            if (pf_grant_i[i]) begin
                case (i)
                    0:       fetch_code = FS_FETCH_MMU;
                    1:       fetch_code = FS_FETCH_EXT;
                    default: fetch_code = FS_ICACHE_PAR;
                endcase
            end
        end
    end

    // Resolve the winning class and its code.
    always_comb begin
        if (lock_i) begin
            cls_o  = CLS_LOCK;
            code_o = FS_LOCK;
        end else if (dmmu_i) begin
            cls_o  = CLS_DMMU;
            code_o = {1'b0, dmmu_code_i};
        end else if (imprecise_i) begin
            cls_o  = CLS_IMPRECISE;
            code_o = {1'b0, dmmu_code_i};
        end else if (pf_any_i) begin
            cls_o  = CLS_FETCH;
            code_o = fetch_code;
        end else begin
            cls_o  = CLS_NONE;
            code_o = 5'b00000;
        end
    end

endmodule

// File: rtl/abort_link_calc.sv
// Module: computes link value and precision attributes for a class.
// Sums wrap modulo 2^AW. Pure combinational logic.
module abort_link_calc
    import abort_cap_pkg::*;
#(
    parameter int AW          = 32,
    parameter int FETCH_OFS   = 4,
    parameter int PRECISE_OFS = 8,
    parameter int IMPREC_OFS  = 4
) (
    input  abort_cls_e     cls_i,
    input  logic [4:0]     code_i,
    input  logic [AW-1:0]  abort_pc_i,
    input  logic [AW-1:0]  next_pc_i,
    output logic [AW-1:0]  link_o,
    output capture_attr_t  attr_o
);

    localparam logic [AW-1:0] FETCH_INC   = AW'(FETCH_OFS);
    localparam logic [AW-1:0] PRECISE_INC = AW'(PRECISE_OFS);
    localparam logic [AW-1:0] IMPREC_INC  = AW'(IMPREC_OFS);

    // Select base, offset and attributes by abort class.
    always_comb begin
        attr_o.code        = code_i;
        attr_o.precise     = 1'b1;
        attr_o.recoverable = 1'b1;
        attr_o.addr_update = 1'b0;
        link_o             = '0;
        unique case (cls_i)
            CLS_FETCH: link_o = abort_pc_i + FETCH_INC;
            CLS_LOCK:  link_o = abort_pc_i + PRECISE_INC;
            CLS_DMMU: begin
                link_o             = abort_pc_i + PRECISE_INC;
                attr_o.addr_update = 1'b1;
            end
            CLS_IMPRECISE: begin
                link_o             = next_pc_i + IMPREC_INC;
                attr_o.precise     = 1'b0;
                attr_o.recoverable = 1'b0;
            end
            default: begin
                attr_o.precise     = 1'b0;
                attr_o.recoverable = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/abort_fault_regs.sv
// Module: architectural fault registers with capture strobe.
// Loads on any class other than NONE; address/domain only when flagged.
module abort_fault_regs
    import abort_cap_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  abort_cls_e    cls_i,
    input  capture_attr_t attr_i,
    input  logic [AW-1:0] link_i,
    input  logic [AW-1:0] data_addr_i,
    input  logic [DW-1:0] domain_i,
    output logic          cap_valid_o,
    output logic [4:0]    fs_code_o,
    output logic [AW-1:0] far_o,
    output logic [DW-1:0] domain_o,
    output logic          addr_valid_o,
    output logic [AW-1:0] link_o,
    output logic          precise_o,
    output logic          recoverable_o
);

    logic take;
    assign take = (cls_i != CLS_NONE);

    // Strobe and status/link capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_valid_o   <= 1'b0;
            fs_code_o     <= '0;
            link_o        <= '0;
            precise_o     <= 1'b0;
            recoverable_o <= 1'b0;
            addr_valid_o  <= 1'b0;
        end else begin
            cap_valid_o <= take;
            if (take) begin
                fs_code_o     <= attr_i.code;
                link_o        <= link_i;
                precise_o     <= attr_i.precise;
                recoverable_o <= attr_i.recoverable;
                addr_valid_o  <= attr_i.addr_update;
            end
        end
    end

    // Fault address and domain capture, only for address-carrying aborts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            far_o    <= '0;
            domain_o <= '0;
        end else if (take && attr_i.addr_update) begin
            far_o    <= data_addr_i;
            domain_o <= domain_i;
        end
    end

endmodule

// File: rtl/abort_capture.sv
// Module: top of the abort fault status capture unit.
// Assumes all abort inputs are single-cycle pulses sampled on posedge clk;
// results appear one cycle later.
module abort_capture
    import abort_cap_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pf_immu_i,
    input  logic          pf_ext_i,
    input  logic          pf_parity_i,
    input  logic          lock_abort_i,
    input  logic          dmmu_abort_i,
    input  logic          imprecise_abort_i,
    input  logic [3:0]    dmmu_code_i,
    input  logic [DW-1:0] domain_i,
    input  logic [AW-1:0] abort_pc_i,
    input  logic [AW-1:0] next_pc_i,
    input  logic [AW-1:0] data_addr_i,
    output logic          cap_valid_o,
    output logic [4:0]    fs_code_o,
    output logic [AW-1:0] far_o,
    output logic [DW-1:0] domain_o,
    output logic          addr_valid_o,
    output logic [AW-1:0] link_o,
    output logic          precise_o,
    output logic          recoverable_o
);

    localparam int NPF = 3;

    logic [NPF-1:0] pf_req;
    logic [NPF-1:0] pf_grant;
    logic           pf_any;
    abort_cls_e     cls;
    logic [4:0]     code;
    logic [AW-1:0]  link_next;
    capture_attr_t  attr;

    assign pf_req = {pf_parity_i, pf_ext_i, pf_immu_i};

    abort_pf_prio #(.NSRC(NPF)) u_prio (
        .req_i   (pf_req),
        .grant_o (pf_grant),
        .any_o   (pf_any)
    );

    abort_class_sel #(.NPF(NPF)) u_sel (
        .pf_grant_i  (pf_grant),
        .pf_any_i    (pf_any),
        .lock_i      (lock_abort_i),
        .dmmu_i      (dmmu_abort_i),
        .imprecise_i (imprecise_abort_i),
        .dmmu_code_i (dmmu_code_i),
        .cls_o       (cls),
        .code_o      (code)
    );

    abort_link_calc #(.AW(AW)) u_link (
        .cls_i      (cls),
        .code_i     (code),
        .abort_pc_i (abort_pc_i),
        .next_pc_i  (next_pc_i),
        .link_o     (link_next),
        .attr_o     (attr)
    );

    abort_fault_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cls_i         (cls),
        .attr_i        (attr),
        .link_i        (link_next),
        .data_addr_i   (data_addr_i),
        .domain_i      (domain_i),
        .cap_valid_o   (cap_valid_o),
        .fs_code_o     (fs_code_o),
        .far_o         (far_o),
        .domain_o      (domain_o),
        .addr_valid_o  (addr_valid_o),
        .link_o        (link_o),
        .precise_o     (precise_o),
        .recoverable_o (recoverable_o)
    );

endmodule

// File: rtl/abort_capture_chk.sv
// Checker: cycle-level properties of abort_capture, bound to every instance.
module abort_capture_chk #(
    parameter int AW = 32,
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pf_immu_i,
    input logic          pf_ext_i,
    input logic          pf_parity_i,
    input logic          lock_abort_i,
    input logic          dmmu_abort_i,
    input logic          imprecise_abort_i,
    input logic [AW-1:0] abort_pc_i,
    input logic [AW-1:0] data_addr_i,
    input logic          cap_valid_o,
    input logic [4:0]    fs_code_o,
    input logic [AW-1:0] far_o,
    input logic          addr_valid_o,
    input logic [AW-1:0] link_o,
    input logic          precise_o,
    input logic          recoverable_o
);

    logic any_abort;
    logic data_side;
    assign any_abort = pf_immu_i | pf_ext_i | pf_parity_i | lock_abort_i
                     | dmmu_abort_i | imprecise_abort_i;
    assign data_side = lock_abort_i | dmmu_abort_i | imprecise_abort_i;

    assert_strobe_after_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_abort |=> cap_valid_o);

    assert_no_strobe_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_abort |=> !cap_valid_o);

    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !any_abort |=> ($stable(fs_code_o) && $stable(far_o) && $stable(link_o)
                        && $stable(precise_o) && $stable(recoverable_o)
                        && $stable(addr_valid_o)));

    assert_fetch_keeps_far_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (any_abort && !data_side) |=>
            (!addr_valid_o && $stable(far_o) && link_o == $past(abort_pc_i) + AW'(4)));

    assert_mmu_fetch_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_immu_i && !data_side) |=> (fs_code_o == 5'b10000));

    assert_dmmu_loads_far_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dmmu_abort_i && !lock_abort_i) |=> (addr_valid_o && far_o == $past(data_addr_i)));

    assert_lock_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lock_abort_i |=> (fs_code_o == 5'b10100 && !addr_valid_o));

    assert_imprecise_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (imprecise_abort_i && !lock_abort_i && !dmmu_abort_i) |=>
            (!precise_o && !recoverable_o));

endmodule

bind abort_capture abort_capture_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .pf_immu_i         (pf_immu_i),
    .pf_ext_i          (pf_ext_i),
    .pf_parity_i       (pf_parity_i),
    .lock_abort_i      (lock_abort_i),
    .dmmu_abort_i      (dmmu_abort_i),
    .imprecise_abort_i (imprecise_abort_i),
    .abort_pc_i        (abort_pc_i),
    .data_addr_i       (data_addr_i),
    .cap_valid_o       (cap_valid_o),
    .fs_code_o         (fs_code_o),
    .far_o             (far_o),
    .addr_valid_o      (addr_valid_o),
    .link_o            (link_o),
    .precise_o         (precise_o),
    .recoverable_o     (recoverable_o)
);

// File: tb/abort_capture_tb.sv
// Bench: exhaustive sweep of all 64 abort input combinations with a
// small address width, against an arithmetic model of the requirements.
module abort_capture_tb;

    localparam int AW = 16;
    localparam int DW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pf_immu_i = 1'b0, pf_ext_i = 1'b0, pf_parity_i = 1'b0;
    logic          lock_abort_i = 1'b0, dmmu_abort_i = 1'b0, imprecise_abort_i = 1'b0;
    logic [3:0]    dmmu_code_i = '0;
    logic [DW-1:0] domain_i = '0;
    logic [AW-1:0] abort_pc_i = '0, next_pc_i = '0, data_addr_i = '0;
    logic          cap_valid_o;
    logic [4:0]    fs_code_o;
    logic [AW-1:0] far_o;
    logic [DW-1:0] domain_o;
    logic          addr_valid_o;
    logic [AW-1:0] link_o;
    logic          precise_o, recoverable_o;

    int n_checks = 0;
    int n_fail   = 0;

    // Model state.
    logic [4:0]    e_code;
    logic [AW-1:0] e_far, e_link;
    logic [DW-1:0] e_dom;
    logic          e_av, e_prec, e_rec;

    always #4 clk = ~clk;

    abort_capture #(.AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .pf_immu_i(pf_immu_i), .pf_ext_i(pf_ext_i), .pf_parity_i(pf_parity_i),
        .lock_abort_i(lock_abort_i), .dmmu_abort_i(dmmu_abort_i),
        .imprecise_abort_i(imprecise_abort_i), .dmmu_code_i(dmmu_code_i),
        .domain_i(domain_i), .abort_pc_i(abort_pc_i), .next_pc_i(next_pc_i),
        .data_addr_i(data_addr_i), .cap_valid_o(cap_valid_o), .fs_code_o(fs_code_o),
        .far_o(far_o), .domain_o(domain_o), .addr_valid_o(addr_valid_o),
        .link_o(link_o), .precise_o(precise_o), .recoverable_o(recoverable_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic vld);
        check("R8", "cap_valid", 32'(cap_valid_o), 32'(vld));
        check(tag, "fs_code", 32'(fs_code_o), 32'(e_code));
        check(tag, "link", 32'(link_o), 32'(e_link));
        check(tag, "far", 32'(far_o), 32'(e_far));
        check(tag, "domain", 32'(domain_o), 32'(e_dom));
        check(tag, "addr_valid", 32'(addr_valid_o), 32'(e_av));
        check(tag, "precise", 32'(precise_o), 32'(e_prec));
        check(tag, "recoverable", 32'(recoverable_o), 32'(e_rec));
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=done");
        finish_run();
    end

    initial begin
        string tag;
        logic [AW-1:0] pc, npc;
        logic [3:0] dc;
        logic any_pf, data_side;
        int npf;

        repeat (3) @(negedge clk);
        e_code = '0; e_far = '0; e_link = '0; e_dom = '0;
        e_av = 0; e_prec = 0; e_rec = 0;
        check_all("R10", 1'b0);
        rst_n = 1'b1;

        for (int v = 0; v < 64; v++) begin
            pc  = 16'hFFF0 + 16'(v * 4);
            npc = pc ^ 16'h0A5C;
            dc  = 4'(v) ^ 4'h5;
            @(negedge clk);
            {imprecise_abort_i, dmmu_abort_i, lock_abort_i,
             pf_parity_i, pf_ext_i, pf_immu_i} = 6'(v);
            abort_pc_i  = pc;
            next_pc_i   = npc;
            data_addr_i = 16'h1234 + 16'(v * 3);
            dmmu_code_i = dc;
            domain_i    = ~4'(v);

            any_pf    = (v[2:0] != 0);
            data_side = (v[5:3] != 0);
            npf       = int'(v[0]) + int'(v[1]) + int'(v[2]);
            tag = "R9";
            if (v[3]) begin
                e_code = 5'b10100; e_link = pc + 16'd8;
                e_prec = 1; e_rec = 1; e_av = 0;
                tag = any_pf || v[4] || v[5] ? "R7" : "R4";
            end else if (v[4]) begin
                e_code = {1'b0, dc}; e_link = pc + 16'd8;
                e_prec = 1; e_rec = 1; e_av = 1;
                e_far = 16'h1234 + 16'(v * 3); e_dom = ~4'(v);
                tag = any_pf || v[5] ? "R7" : "R5";
            end else if (v[5]) begin
                e_code = {1'b0, dc}; e_link = npc + 16'd4;
                e_prec = 0; e_rec = 0; e_av = 0;
                tag = any_pf ? "R7" : "R6";
            end else if (any_pf) begin
                e_code = v[0] ? 5'b10000 : (v[1] ? 5'b10110 : 5'b11000);
                e_link = pc + 16'd4;
                e_prec = 1; e_rec = 1; e_av = 0;
                tag = (npf > 1) ? "R1" : "R2";
            end
            if (!data_side && any_pf && pc > 16'hFFFB) tag = "R11";
            if (data_side && v[5:4] == 2'b00 && pc > 16'hFFF7) tag = "R11";

            @(negedge clk);
            check_all(tag, (v != 0));
            // R3: fetch-only captures must also keep far/domain (covered by model).
            {imprecise_abort_i, dmmu_abort_i, lock_abort_i,
             pf_parity_i, pf_ext_i, pf_immu_i} = 6'b0;
            abort_pc_i = 16'h5555; data_addr_i = 16'hAAAA; domain_i = 4'hF;

            @(negedge clk);
            check_all((any_pf && !data_side) ? "R3" : "R9", 1'b0);
        end

        // R10: reset mid-run clears captured state.
        rst_n = 1'b0;
        @(negedge clk);
        e_code = '0; e_far = '0; e_link = '0; e_dom = '0;
        e_av = 0; e_prec = 0; e_rec = 0;
        check_all("R10", 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_run();
    end

endmodule